// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

A single-lane integer shift unit for one element of 8, 16, 32 or 64 bits. A signed shift count picks the direction: positive counts shift left, negative counts shift right by the magnitude of the count. Right shifts may round half-up. Left shifts may clamp to the largest representable value when they overflow the element. Three interpretations of the data are available: signed in and signed out, unsigned in and unsigned out, and a mixed form that reads a signed element and produces an unsigned one.

Each operation is presented with a valid strobe. The result appears one clock later, right-aligned in a 64-bit word and extended to 64 bits according to the signedness of the result. It comes with a flag that reports whether saturation took place. The unit is meant to be replicated by the surrounding datapath, one copy per lane.

Top module: `sat_rnd_shifter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `sat_flag` is high only in a cycle whose `out_valid` is high. `result` updates only on a valid operation. An active-low synchronous reset clears `out_valid`, `sat_flag` and `result`.
- R2: `esize` selects the element width W: 0 for 8, 1 for 16, 2 for 32, 3 for 64. `mode` selects the data type: 0 is signed, 1 is unsigned, 2 is signed-to-unsigned, and 3 behaves like 1. `shamt` is an 8-bit two's-complement count. Only the low W bits of `src` are used.
- R3: A negative count greater than -W shifts right by its magnitude. The shift is arithmetic in mode 0 and logical in the other modes.
- R4: With `rnd_en` set, a right shift by n first shifts by n-1, then shifts the intermediate right by one more bit and adds the bit that was dropped (round half-up).
- R5: In mode 0, a count at or below -W gives 0 when rounding is on, and otherwise gives the sign bit repeated over the element.
- R6: In the unsigned modes, a count at or below -(W + `rnd_en`) gives 0.
- R7: A left shift by less than W whose result still represents the source in W bits returns the shifted value with no flag.
- R8: In mode 0 with `sat_en`, an overflowing left shift returns 2^(W-1)-1 for a non-negative source and -2^(W-1) for a negative source, and raises `sat_flag`.
- R9: In the unsigned modes with `sat_en`, an overflowing left shift returns W ones and raises `sat_flag`.
- R10: A left count of W or more gives 0 when the source is zero or `sat_en` is low. Otherwise it saturates as in R8 or R9.
- R11: With `sat_en` low, an overflowing left shift wraps to the low W bits of the shifted value, and `sat_flag` stays low.
- R12: In mode 2 with `sat_en`, a negative source returns 0 and raises `sat_flag` for any count. With `sat_en` low, the source bits are treated as unsigned.
- R13: Signed results are sign-extended from W to 64 bits and unsigned results are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 64 | Source element, right-aligned |
| shamt | input | 8 | Signed shift count |
| esize | input | 2 | Element width select |
| mode | input | 2 | Data type select |
| rnd_en | input | 1 | Round right shifts |
| sat_en | input | 1 | Saturate left shifts |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 64 | Shifted element, extended to 64 bits |
| sat_flag | output | 1 | Saturation occurred |

## Verification
The assertions assume that every control input is a defined value during each cycle in which `in_valid` is high, and that reset is held for at least one clock edge before the first operation. The bench drives all inputs on the falling edge, and it holds reset low over several edges before it issues any operation. Between operations it keeps the data and control inputs defined, so an idle cycle never presents unknown values to the shifter.

// File: rtl/sat_rnd_shifter.sv
module sat_rnd_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src,
  input  logic [7:0]  shamt,
  input  logic [1:0]  esize,
  input  logic [1:0]  mode,
  input  logic        rnd_en,
  input  logic        sat_en,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        sat_flag
);

  logic [6:0]         w;
  logic [63:0]        wmask, zx, sx;
  logic               msb, sgn;
  logic signed [64:0] xs;

  assign w     = 7'd8 << esize;
  assign wmask = ~64'd0 >> (7'd64 - w);
  assign msb   = src[w - 7'd1];
  assign sgn   = (mode == 2'd0);
  assign zx    = src & wmask;
  assign sx    = zx | (msb ? ~wmask : 64'd0);
  assign xs    = sgn ? $signed({sx[63], sx}) : $signed({1'b0, zx});

  // right shift path
  logic signed [9:0]  sh10;
  logic [7:0]         lim, nmag, nm1;
  logic               far_r;
  logic signed [64:0] t, th;
  logic [63:0]        r_out;

  assign sh10  = $signed({{2{shamt[7]}}, shamt});
  assign lim   = {1'b0, w} + {7'd0, rnd_en & ~sgn};
  assign far_r = (sh10 + $signed({2'b00, lim})) <= 10'sd0;
  assign nmag  = 8'd0 - shamt;
  assign nm1   = nmag - 8'd1;
  assign t     = xs >>> nm1;
  assign th    = t >>> 1;
  assign r_out = rnd_en ? 64'(th + {64'd0, t[0]}) : 64'(xs >>> nmag);

  // left shift path
  logic [127:0] p;
  logic [63:0]  fz, fs, f, smax, satv;
  logic         fits;

  assign p    = {{63{xs[64]}}, xs} << shamt[5:0];
  assign fz   = p[63:0] & wmask;
  assign fs   = fz | (p[w - 7'd1] ? ~wmask : 64'd0);
  assign f    = sgn ? fs : fz;
  assign fits = ({{64{sgn & f[63]}}, f} == p);
  assign smax = wmask >> 1;
  assign satv = sgn ? (xs[64] ? ~smax : smax) : wmask;

  logic [63:0] res;
  logic        ov;

  always_comb begin
    res = 64'd0;
    ov  = 1'b0;
    if (mode == 2'd2 && sat_en && msb) begin
      ov = 1'b1;
    end else if (shamt[7]) begin
      if (!far_r)
        res = r_out;
      else if (sgn && !rnd_en)
        res = {64{xs[64]}};
    end else if (shamt[6:0] < w) begin
      if (fits || !sat_en) res = f;
      else begin
        res = satv;
        ov  = 1'b1;
      end
    end else if (sat_en && xs != 65'sd0) begin
      res = satv;
      ov  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sat_flag  <= 1'b0;
      result    <= 64'd0;
    end else begin
      out_valid <= in_valid;
      sat_flag  <= in_valid & ov;
      if (in_valid) result <= res;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !sat_flag));
  a_r11_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en) |=> !sat_flag);
  a_r12_neg_clamps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && sat_en && msb) |=> (sat_flag && result == 64'd0));
  a_r13_unsigned_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'd0) |=> ((result & ~$past(wmask)) == 64'd0));
  a_r9_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1) |=> (!sat_flag || result == $past(wmask)));
  a_r7_zero_count_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shamt == 8'd0 && mode != 2'd2) |=> !sat_flag);

endmodule

// File: tb/tb_sat_rnd_shifter.sv
`timescale 1ns/1ps
module tb_sat_rnd_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src = 64'd0;
  logic [7:0]  shamt = 8'd0;
  logic [1:0]  esize = 2'd0;
  logic [1:0]  mode = 2'd0;
  logic        rnd_en = 1'b0;
  logic        sat_en = 1'b0;
  logic        out_valid, sat_flag;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] ONES = ~64'd0;

  always #10 clk = ~clk;

  sat_rnd_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .shamt(shamt),
    .esize(esize), .mode(mode), .rnd_en(rnd_en), .sat_en(sat_en),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag));

  task automatic op(input logic [63:0] s, input logic [7:0] sh, input logic [1:0] sz,
                    input logic [1:0] md, input logic r, input logic st,
                    input logic [63:0] er, input logic ef, input string tag);
    @(negedge clk);
    in_valid = 1'b1; src = s; shamt = sh; esize = sz; mode = md; rnd_en = r; sat_en = st;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1 || result !== er || sat_flag !== ef) begin
      errors++;
      $display("FAIL %s: valid=%b result=%h flag=%b, expected valid=1 result=%h flag=%b",
               tag, out_valid, result, sat_flag, er, ef);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || sat_flag !== 1'b0 || result !== 64'd0) begin
      errors++;
      $display("FAIL R1 reset: valid=%b flag=%b result=%h, expected 0 0 0", out_valid, sat_flag, result);
    end
  endtask

  task automatic t_right_plain;
    op(64'h90, 8'hFE, 2'd0, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFE4, 0, "R3 signed asr");
    op(64'h90, 8'hFE, 2'd0, 2'd1, 0, 0, 64'h24, 0, "R3 unsigned lsr");
  endtask

  task automatic t_round;
    op(64'h07, 8'hFE, 2'd0, 2'd0, 1, 0, 64'h2, 0, "R4 round pos");
    op(64'hF9, 8'hFE, 2'd0, 2'd0, 1, 0, ONES - 64'd1, 0, "R4 round neg");
    op(64'hFFFF, 8'hF0, 2'd1, 2'd1, 1, 0, 64'h1, 0, "R4 round by width");
  endtask

  task automatic t_far_right;
    op(64'h8000_0000, 8'hE0, 2'd2, 2'd0, 0, 0, ONES, 0, "R5 sign fill");
    op(64'h8000_0000, 8'hE0, 2'd2, 2'd0, 1, 0, 64'd0, 0, "R5 round zero");
    op(64'hFFFF, 8'hEF, 2'd1, 2'd1, 1, 0, 64'd0, 0, "R6 beyond width+1");
    op(64'hFFFF, 8'hF0, 2'd1, 2'd1, 0, 0, 64'd0, 0, "R6 width no round");
  endtask

  task automatic t_left_fit;
    op(64'h0123, 8'd4, 2'd1, 2'd0, 0, 1, 64'h1230, 0, "R7 fits 16");
    op(64'h1, 8'd62, 2'd3, 2'd0, 0, 1, 64'h4000_0000_0000_0000, 0, "R7 fits 64");
    op(64'hFF, 8'd7, 2'd0, 2'd0, 0, 1, 64'hFFFF_FFFF_FFFF_FF80, 0, "R7 reach min");
    op(64'h01, 8'd7, 2'd0, 2'd1, 0, 1, 64'h80, 0, "R7 unsigned msb");
  endtask

  task automatic t_saturate;
    op(64'h40, 8'd1, 2'd0, 2'd0, 0, 1, 64'h7F, 1, "R8 signed max");
    op(64'h80, 8'd1, 2'd0, 2'd0, 0, 1, 64'hFFFF_FFFF_FFFF_FF80, 1, "R8 signed min");
    op(64'h4000_0000_0000_0000, 8'd1, 2'd3, 2'd0, 0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 1, "R8 max 64");
    op(64'h8000_0000, 8'd1, 2'd2, 2'd1, 0, 1, 64'hFFFF_FFFF, 1, "R9 unsigned 32");
  endtask

  task automatic t_big_left;
    op(64'h0, 8'd8, 2'd0, 2'd0, 0, 1, 64'd0, 0, "R10 zero src");
    op(64'h1, 8'd8, 2'd0, 2'd0, 0, 1, 64'h7F, 1, "R10 saturate");
    op(64'h1, 8'd8, 2'd0, 2'd0, 0, 0, 64'd0, 0, "R10 sat off");
    op(64'h5, 8'd100, 2'd3, 2'd1, 0, 1, ONES, 1, "R10 unsigned 64");
    op(64'h8000, 8'd127, 2'd1, 2'd0, 0, 1, 64'hFFFF_FFFF_FFFF_8000, 1, "R10 neg count max");
  endtask

  task automatic t_wrap;
    op(64'h40, 8'd1, 2'd0, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FF80, 0, "R11 signed wrap");
    op(64'h8001, 8'd1, 2'd1, 2'd1, 0, 0, 64'h2, 0, "R11 unsigned wrap");
  endtask

  task automatic t_mixed;
    op(64'hFF, 8'd0, 2'd0, 2'd2, 0, 1, 64'd0, 1, "R12 negative clamps");
    op(64'hFF, 8'hFC, 2'd0, 2'd2, 0, 0, 64'h0F, 0, "R12 sat off as unsigned");
    op(64'h7F, 8'd1, 2'd0, 2'd2, 0, 1, 64'hFE, 0, "R12 positive fits");
    op(64'h7F, 8'd2, 2'd0, 2'd2, 0, 1, 64'hFF, 1, "R12 positive overflow");
  endtask

  task automatic t_encoding;
    op(64'hABCD_EF01_2345_6702, 8'd1, 2'd0, 2'd0, 0, 0, 64'h04, 0, "R2 upper bits ignored");
    op(64'h90, 8'hFE, 2'd0, 2'd3, 0, 0, 64'h24, 0, "R2 mode 3 unsigned");
    op(64'h8000, 8'd0, 2'd1, 2'd1, 0, 0, 64'h8000, 0, "R13 zero extend");
    op(64'h8000, 8'd0, 2'd1, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_8000, 0, "R13 sign extend");
  endtask

  task automatic t_idle;
    op(64'h40, 8'd1, 2'd0, 2'd0, 0, 1, 64'h7F, 1, "R1 flagged op");
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sat_flag !== 1'b0 || result !== 64'h7F) begin
      errors++;
      $display("FAIL R1 idle: valid=%b flag=%b result=%h, expected 0 0 7f", out_valid, sat_flag, result);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_right_plain();
    t_round();
    t_far_right();
    t_left_fit();
    t_saturate();
    t_big_left();
    t_wrap();
    t_mixed();
    t_encoding();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule